// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

This block watches the access strobes of the two ports of a shared memory and raises a message interrupt from one port to the other. The two highest addresses of the memory serve as mailboxes. The second-highest word belongs to port A and the highest word belongs to port B. When a port writes a message into its partner's mailbox, the partner's active-low interrupt goes low. The interrupt stays low until the partner reads its own mailbox. The data itself stays in the ordinary memory, and software decides what it means.

No control register exists. Interrupts are set and cleared only as side effects of memory accesses that the unit snoops. Each port presents an address, a select and a write strobe. On every rising clock edge where the select is high, the unit counts one access. A write strobe of 1 marks a write and 0 marks a read.

Each owner has its own flag machine with two states, IDLE and PENDING. The transition POST (IDLE to PENDING) happens when the partner writes the owner's mailbox. The transition TAKE (PENDING to IDLE) happens when the owner reads its own mailbox and no POST arrives in the same cycle. The transition REPOST (PENDING to PENDING) covers every other case in PENDING, including a POST and a TAKE in the same cycle. HOLD (IDLE to IDLE) covers every other case in IDLE.

Top module: `dpmbx_irq_unit`

## Requirements
- R1: After reset both `a_irq_n` and `b_irq_n` are 1 (deasserted).
- R2: Port A's mailbox is at address 2^AW-2 and port B's mailbox is at 2^AW-1. With the default AW=13 these are 0x1FFE and 0x1FFF.
- R3: A port B access with `b_sel`=1, `b_wr`=1 and `b_addr` equal to A's mailbox drives `a_irq_n` to 0 after the next rising edge.
- R4: A port A access with `a_sel`=1, `a_wr`=1 and `a_addr` equal to B's mailbox drives `b_irq_n` to 0 after the next rising edge.
- R5: An owner read of its own mailbox (select 1, write strobe 0) returns that owner's interrupt to 1 after the next rising edge.
- R6: An asserted interrupt stays 0 through further mailbox writes and unrelated accesses until the owner's own read clears it.
- R7: A port writing its own mailbox changes neither interrupt.
- R8: A port reading its partner's mailbox changes neither interrupt.
- R9: If a set and a clear for the same owner fall in the same cycle, the interrupt is 0 after that edge.
- R10: Accesses with the select at 0, and accesses to any non-mailbox address, change neither interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | AW | Port A address |
| a_sel | input | 1 | Port A access select |
| a_wr | input | 1 | Port A write strobe (1 write, 0 read) |
| b_addr | input | AW | Port B address |
| b_sel | input | 1 | Port B access select |
| b_wr | input | 1 | Port B write strobe (1 write, 0 read) |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
The bench drives four kinds of access to the two mailbox words: cross writes, own reads, own writes and cross reads. Cross writes and own reads must toggle the interrupts. Own writes and cross reads must leave them alone, which shows that the unit decodes direction and ownership, not just the address. Further patterns cover deselected accesses, an address next to the mailboxes, repeated writes while an interrupt is pending, and a set and a clear in the same cycle. Together these separate a correctly sticky, set-priority flag from one that clears early or lets the clear win.

// File: rtl/dpmbx_pkg.sv
package dpmbx_pkg;
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;

    localparam int unsigned PORTS = 2;
endpackage

// File: rtl/dpmbx_decode.sv
module dpmbx_decode #(
    parameter int unsigned AW   = 13,
    parameter int unsigned SELF = 0
) (
    input  logic [AW-1:0] addr,
    input  logic          sel,
    input  logic          wr,
    output logic          post_peer,
    output logic          take_own
);
    localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] OWN_BOX   = (SELF == 0) ? TOP_ADDR - 1'b1 : TOP_ADDR;
    localparam logic [AW-1:0] PEER_BOX  = (SELF == 0) ? TOP_ADDR : TOP_ADDR - 1'b1;

    always_comb begin
        post_peer = sel &&  wr && (addr == PEER_BOX);
        take_own  = sel && !wr && (addr == OWN_BOX);
    end
endmodule

// File: rtl/dpmbx_flag.sv
module dpmbx_flag
    import dpmbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic take,
    output logic irq_n
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (post) state_d = FLAG_PENDING;
            FLAG_PENDING: if (take && !post) state_d = FLAG_IDLE;
            default:      state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        irq_n = (state_q != FLAG_PENDING);
    end

    assert_post_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> !irq_n);
    assert_take_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !post) |=> irq_n);
    assert_quiet_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !post) |=> $stable(irq_n));
    assert_post_beats_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && post) |=> !irq_n);
endmodule

// File: rtl/dpmbx_irq_unit.sv
module dpmbx_irq_unit
    import dpmbx_pkg::*;
#(
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_sel,
    input  logic          a_wr,
    input  logic [AW-1:0] b_addr,
    input  logic          b_sel,
    input  logic          b_wr,
    output logic          a_irq_n,
    output logic          b_irq_n
);
    logic [AW-1:0]    addr_v [PORTS];
    logic [PORTS-1:0] sel_v, wr_v, post_v, take_v, irq_v;

    always_comb begin
        addr_v[0] = a_addr;
        addr_v[1] = b_addr;
        sel_v     = {b_sel, a_sel};
        wr_v      = {b_wr, a_wr};
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        dpmbx_decode #(.AW(AW), .SELF(p)) u_dec (
            .addr      (addr_v[p]),
            .sel       (sel_v[p]),
            .wr        (wr_v[p]),
            .post_peer (post_v[p]),
            .take_own  (take_v[p])
        );
        dpmbx_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .post  (post_v[PORTS-1-p]),
            .take  (take_v[p]),
            .irq_n (irq_v[p])
        );
    end

    assign a_irq_n = irq_v[0];
    assign b_irq_n = irq_v[1];

    assert_cross_write_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sel && a_wr && a_addr == {AW{1'b1}}) |=> !b_irq_n);
endmodule

// File: tb/test_dpmbx_irq_unit.sv
module test_dpmbx_irq_unit;
    localparam int unsigned AW = 13;
    localparam logic [AW-1:0] BOX_A = 13'h1FFE;
    localparam logic [AW-1:0] BOX_B = 13'h1FFF;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] a_addr, b_addr;
    logic a_sel, a_wr, b_sel, b_wr;
    logic a_irq_n, b_irq_n;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dpmbx_irq_unit #(.AW(AW)) i_dpmbx_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_sel(a_sel), .a_wr(a_wr),
        .b_addr(b_addr), .b_sel(b_sel), .b_wr(b_wr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    task automatic check(input string req, input logic ea, input logic eb);
        checks++;
        if (a_irq_n !== ea || b_irq_n !== eb) begin
            errors++;
            $display("FAIL %s a_irq_n=%b b_irq_n=%b expected %b %b", req, a_irq_n, b_irq_n, ea, eb);
        end
    endtask

    task automatic cycle(input logic as, input logic aw, input logic [AW-1:0] aa,
                         input logic bs, input logic bw, input logic [AW-1:0] ba);
        @(negedge clk);
        a_sel = as; a_wr = aw; a_addr = aa;
        b_sel = bs; b_wr = bw; b_addr = ba;
        @(negedge clk);
        a_sel = 0; b_sel = 0; a_wr = 0; b_wr = 0;
    endtask

    task automatic t_reset;
        rst_n = 0; a_sel = 0; b_sel = 0; a_wr = 0; b_wr = 0; a_addr = '0; b_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset", 1, 1);
    endtask

    task automatic t_set_clear;
        cycle(0, 0, 0, 1, 1, BOX_A); check("R3 B writes A box (R2 0x1FFE)", 0, 1);
        cycle(1, 0, BOX_A, 0, 0, 0); check("R5 A reads own box", 1, 1);
        cycle(1, 1, BOX_B, 0, 0, 0); check("R4 A writes B box (R2 0x1FFF)", 1, 0);
        cycle(0, 0, 0, 1, 0, BOX_B); check("R5 B reads own box", 1, 1);
    endtask

    task automatic t_own_write;
        cycle(1, 1, BOX_A, 1, 1, BOX_B); check("R7 own-box writes", 1, 1);
    endtask

    task automatic t_cross_read;
        cycle(0, 0, 0, 1, 1, BOX_A);
        cycle(1, 0, BOX_B, 0, 0, 0); check("R8 A reads B box", 0, 1);
        cycle(0, 0, 0, 1, 0, BOX_A); check("R8 B reads A box", 0, 1);
        cycle(1, 0, BOX_A, 0, 0, 0); check("R5 clear after cross reads", 1, 1);
    endtask

    task automatic t_sticky;
        cycle(1, 1, BOX_B, 0, 0, 0);
        cycle(1, 1, BOX_B, 0, 0, 0); check("R6 repeated write", 1, 0);
        cycle(1, 1, 13'h0042, 1, 1, 13'h1FFD); check("R6 unrelated access", 1, 0);
        repeat (3) @(negedge clk);
        check("R6 idle cycles", 1, 0);
        cycle(0, 0, 0, 1, 0, BOX_B); check("R5 clear sticky", 1, 1);
    endtask

    task automatic t_simul;
        cycle(0, 0, 0, 1, 1, BOX_A);
        cycle(1, 0, BOX_A, 1, 1, BOX_A); check("R9 set and clear together", 0, 1);
        cycle(1, 0, BOX_A, 0, 0, 0); check("R5 clear after R9", 1, 1);
    endtask

    task automatic t_inactive;
        cycle(0, 1, BOX_B, 0, 1, BOX_A); check("R10 deselected writes", 1, 1);
        cycle(1, 1, 13'h1FFD, 1, 1, 13'h0FFF); check("R10 near-miss addresses", 1, 1);
        cycle(0, 0, 0, 1, 1, BOX_A);
        cycle(0, 0, BOX_A, 0, 0, 0); check("R10 deselected read no clear", 0, 1);
        cycle(1, 0, BOX_A, 0, 0, 0); check("R5 final clear", 1, 1);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_set_clear;
                t_own_write;
                t_cross_read;
                t_sticky;
                t_simul;
                t_inactive;
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule